// File: doc/BRIEF.md
# Handshaked Program/Data Memory

This block is the single store of a small processor: one 64-word array that holds both the program and the working data. The processor reaches it over one shared bus. It places an address and a direction, raises a select line, and waits for a ready response. It then drops select to end the transfer. Each select pulse causes exactly one access. The address, direction and write data may change while ready is high without any effect.

Words are 16 bits so that one word holds a whole instruction. The lower sixteen locations form the instruction region. A write there stores the full word. The remaining locations form the data region. A write there keeps only the low byte and clears the upper byte. The bus carries an 8-bit address. Any address whose upper two bits are not zero lies outside the array: a write to it is dropped, and a read from it returns zero. Reset loads a fixed image that the package computes. This image holds a small default program and a run of data bytes.

Top module: `hsmem_top`

## Requirements
- R1: After reset, ready is 0, rdata is 0, and the array holds the following image. Word i for i from 0 to 13 is ((i+1)*0x0841) mod 0x10000. Words 14 and 15 are 0. Word 16+k for k from 0 to 14 is k+1. Words 31 to 63 are 0.
- R2: When sel is sampled high with ready low, ready is 1 after the next rising edge. It stays 1 for as long as sel stays high.
- R3: When sel is sampled low while ready is 1, ready and rdata are both 0 after the next rising edge.
- R4: A read (rw=0) to an address in 0x00..0x3F presents the word that was stored at that address at the accepting edge. It appears on rdata in the same cycle that ready rises.
- R5: While ready stays high, rdata does not change, even when addr changes.
- R6: A write (rw=1) to an address in 0x00..0x0F stores all 16 bits of wdata.
- R7: A write to an address in 0x10..0x3F stores wdata[7:0] with bits 15:8 cleared.
- R8: An address with addr[7:6] not 0 leaves the array unchanged on a write. The location it would alias to is not touched. A read from it returns 0.
- R9: Only one access happens per select pulse. Changes to addr, rw or wdata while ready is high write nothing and read nothing.
- R10: rdata is 0 whenever ready is 0, and it is also 0 during the ready phase of a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; reloads the image |
| addr | input | 8 | Word address; bits 7:6 must be zero to hit the array |
| rw | input | 1 | Direction: 1 write, 0 read |
| sel | input | 1 | Select; high requests an access, low ends it |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while ready is high |
| ready | output | 1 | Access complete |

## Verification
The embedded assertions check the handshake on every cycle. They cover the rise of ready one edge after select, its hold while select stays high, and its release together with the clearing of rdata. They also check that rdata is stable during a hold, that rdata is zero when ready is low, and that the upper byte is clear on every data-region write strobe. The following can only be shown through the bench's scenarios, by reading back through the bus: the contents of the reset image, the lane masking per region, the dropping of out-of-range writes without touching the aliased word, and the fact that bus changes during a hold do not write again.

// File: rtl/hsmem_pkg.sv
package hsmem_pkg;

    localparam int ADDR_W      = 8;
    localparam int WORD_W      = 16;
    localparam int LANE_W      = 8;
    localparam int IDX_W       = 6;
    localparam int DEPTH       = 1 << IDX_W;
    localparam int INSTR_WORDS = 16;
    localparam int PROG_WORDS  = 14;
    localparam int DATA_FILL   = 15;
    localparam int PROG_STEP   = 16'h0841;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } hs_state_t;

    typedef enum logic [0:0] {
        REG_INSTR = 1'b0,
        REG_DATA  = 1'b1
    } region_t;

    typedef struct packed {
        logic             hit;
        region_t          region;
        logic [IDX_W-1:0] idx;
    } decode_t;

    function automatic logic [WORD_W-1:0] init_word(input int idx);
        if (idx < PROG_WORDS)
            return WORD_W'((idx + 1) * PROG_STEP);
        else if (idx >= INSTR_WORDS && idx < INSTR_WORDS + DATA_FILL)
            return WORD_W'(idx - INSTR_WORDS + 1);
        else
            return '0;
    endfunction

endpackage

// File: rtl/hsmem_decode.sv
module hsmem_decode
    import hsmem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = IDX_W
) (
    input  logic [AW-1:0] addr,
    output decode_t       dec
);
    localparam int HI_W = AW - IW;

    always_comb begin
        dec.hit    = (addr[AW-1:IW] == HI_W'(0));
        dec.idx    = addr[IW-1:0];
        dec.region = (int'(addr[IW-1:0]) < INSTR_WORDS) ? REG_INSTR : REG_DATA;
    end
endmodule

// File: rtl/hsmem_array.sv
module hsmem_array
    import hsmem_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [WW-1:0] wword,
    input  logic [IW-1:0] ridx,
    output logic [WW-1:0] rword
);
    localparam int N = 1 << IW;

    logic [WW-1:0] store [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++)
                store[i] <= init_word(i);
        end else if (we) begin
            store[widx] <= wword;
        end
    end

    assign rword = store[ridx];

    // R7: data-region strobes from the controller carry a cleared upper byte
    assert_data_upper_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (we && int'(widx) >= INSTR_WORDS) |-> (wword[WW-1:LANE_W] == '0));
endmodule

// File: rtl/hsmem_ctrl.sv
module hsmem_ctrl
    import hsmem_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int LW = LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          rw,
    input  decode_t       dec,
    input  logic [WW-1:0] wdata,
    input  logic [WW-1:0] rword,
    output logic          we,
    output logic [WW-1:0] wword,
    output logic [WW-1:0] rdata,
    output logic          ready
);
    hs_state_t state;
    logic      accept;

    assign accept = (state == ST_IDLE) && sel;
    assign we     = accept && rw && dec.hit;
    assign ready  = (state == ST_DONE);

    always_comb begin
        if (dec.region == REG_INSTR)
            wword = wdata;
        else
            wword = {{(WW-LW){1'b0}}, wdata[LW-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sel) begin
                        state <= ST_DONE;
                        rdata <= (!rw && dec.hit) ? rword : '0;
                    end else begin
                        rdata <= '0;
                    end
                end
                ST_DONE: begin
                    if (!sel) begin
                        state <= ST_IDLE;
                        rdata <= '0;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    rdata <= '0;
                end
            endcase
        end
    end

    // R2: select seen while idle leads to ready on the next edge
    assert_ready_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (sel && !ready) |=> ready);
    // R2: ready is held while select stays high
    assert_ready_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (sel && ready) |=> ready);
    // R3: release clears ready and data together
    assert_release_R3: assert property (@(posedge clk) disable iff (rst)
        (!sel && ready) |=> (!ready && rdata == '0));
    // R5: data stays put across a hold
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (sel && ready) |=> $stable(rdata));
    // R10: no stale data outside the ready phase
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (rdata == '0));
endmodule

// File: rtl/hsmem_top.sv
module hsmem_top
    import hsmem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WORD_W,
    parameter int LW = LANE_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rw,
    input  logic          sel,
    input  logic [WW-1:0] wdata,
    output logic [WW-1:0] rdata,
    output logic          ready
);
    decode_t       dec;
    logic          we;
    logic [WW-1:0] wword;
    logic [WW-1:0] rword;

    hsmem_decode #(.AW(AW), .IW(IW)) u_decode (
        .addr (addr),
        .dec  (dec)
    );

    hsmem_array #(.WW(WW), .IW(IW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .widx  (dec.idx),
        .wword (wword),
        .ridx  (dec.idx),
        .rword (rword)
    );

    hsmem_ctrl #(.WW(WW), .LW(LW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .rw    (rw),
        .dec   (dec),
        .wdata (wdata),
        .rword (rword),
        .we    (we),
        .wword (wword),
        .rdata (rdata),
        .ready (ready)
    );
endmodule

// File: tb/hsmem_top_tb_top.sv
`timescale 1ns/1ps
module hsmem_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        rw = 1'b0;
    logic        sel = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ready;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hsmem_top dut_i (
        .clk(clk), .rst(rst), .addr(addr), .rw(rw), .sel(sel),
        .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    function automatic logic [15:0] image_word(input int i);
        if (i <= 13) return 16'(((i + 1) * 32'h0841) % 32'h10000);
        if (i >= 16 && i <= 30) return 16'(i - 15);
        return 16'h0000;
    endfunction

    // behavioural reference model, advanced every rising edge
    logic [15:0] m_mem [64];
    logic        m_ready = 1'b0;
    logic [15:0] m_rdata = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) m_mem[i] <= image_word(i);
            m_ready <= 1'b0;
            m_rdata <= '0;
        end else if (!m_ready && sel) begin
            m_ready <= 1'b1;
            if (addr < 8'd64) begin
                if (rw) begin
                    m_mem[addr] <= (addr < 8'd16) ? wdata : {8'h00, wdata[7:0]};
                    m_rdata <= '0;
                end else begin
                    m_rdata <= m_mem[addr];
                end
            end else begin
                m_rdata <= '0;
            end
        end else if (m_ready && !sel) begin
            m_ready <= 1'b0;
            m_rdata <= '0;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R4 data path, R2 handshake)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 model ready", {15'h0, ready}, {15'h0, m_ready});
            check("R4 model rdata", rdata, m_rdata);
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            summary();
        end
    end

    // one handshake: select, sample ready, optional hold with bus changes, release
    task automatic access(input logic [7:0] a, input logic r, input logic [15:0] w,
                          input int hold, input logic [7:0] alt_a, input logic [15:0] alt_w,
                          output logic [15:0] rd);
        @(negedge clk);
        addr = a; rw = r; wdata = w; sel = 1'b1;
        @(negedge clk);
        check("R2 ready after select", {15'h0, ready}, 16'h0001);
        rd = rdata;
        if (r) check("R10 zero data on write", rdata, 16'h0000);
        for (int k = 0; k < hold; k++) begin
            addr = alt_a; wdata = alt_w;
            @(negedge clk);
            check("R2 ready held", {15'h0, ready}, 16'h0001);
            check("R5 data held", rdata, rd);
        end
        sel = 1'b0; addr = '0; wdata = '0;
        @(negedge clk);
        check("R3 ready released", {15'h0, ready}, 16'h0000);
        check("R3 data cleared", rdata, 16'h0000);
    endtask

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset ready", {15'h0, ready}, 16'h0000);
        check("R1 reset rdata", rdata, 16'h0000);

        // R1 / R4: full image readback
        for (int i = 0; i < 64; i++) begin
            access(8'(i), 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
            check("R1 image word", rd, image_word(i));
        end
        access(8'h0D, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R1 last program word", rd, 16'h738E);
        access(8'h1E, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R1 last data fill", rd, 16'h000F);

        // R6: instruction region full word
        access(8'h05, 1'b1, 16'hBEEF, 0, 8'h0, 16'h0, rd);
        access(8'h05, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R6 full word stored", rd, 16'hBEEF);
        access(8'h0F, 1'b1, 16'h8001, 0, 8'h0, 16'h0, rd);
        access(8'h0F, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R6 region top word", rd, 16'h8001);

        // R7: data region low lane
        access(8'h20, 1'b1, 16'h12A5, 0, 8'h0, 16'h0, rd);
        access(8'h20, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R7 upper byte cleared", rd, 16'h00A5);
        access(8'h10, 1'b1, 16'hFFFF, 0, 8'h0, 16'h0, rd);
        access(8'h10, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R7 region bottom word", rd, 16'h00FF);

        // R8: out-of-range addresses
        access(8'h85, 1'b1, 16'h1111, 0, 8'h0, 16'h0, rd);
        access(8'h05, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R8 alias untouched", rd, 16'hBEEF);
        access(8'h85, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R8 out-of-range read", rd, 16'h0000);
        access(8'hC1, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R8 high read zero", rd, 16'h0000);

        // R5: hold with address change
        access(8'h11, 1'b0, 16'h0, 4, 8'h12, 16'h0, rd);
        check("R5 held read value", rd, 16'h0002);

        // R9: hold during write with bus changes
        access(8'h30, 1'b1, 16'h0077, 3, 8'h31, 16'h0099, rd);
        access(8'h30, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R9 single write", rd, 16'h0077);
        access(8'h31, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R9 no second write", rd, 16'h0000);

        // R10: idle output stays zero while address wanders
        @(negedge clk);
        addr = 8'h01;
        @(negedge clk);
        check("R10 idle rdata", rdata, 16'h0000);

        // R1: reset restores the image
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        access(8'h05, 1'b0, 16'h0, 0, 8'h0, 16'h0, rd);
        check("R1 reload after reset", rd, 16'h3186);

        done = 1;
        summary();
    end
endmodule